// File: doc/BRIEF.md
# Asynchronous Serial Port Control and Interrupt Block

This block is the register-mapped front end of an asynchronous serial port. A processor reaches it through a small bus with a two-bit address, separate read and write strobes, and byte-wide data. Through this bus it sets the port's enables, loads the byte to transmit and reads back the received byte and the status flags. The bit shifter, the baud timing and the line itself are not part of this block. They appear here only as single-cycle event pulses: the shifter has taken the transmit byte, a start bit was seen, a byte was completed (with framing and parity error qualifiers), and the block emits a start pulse toward the shifter.

The status flags can only be withdrawn by a deliberate two-step handshake. Software must first read the status register while a flag shows 1. A later write of 0 to that flag's position then clears it. A write of 0 that was not preceded by such a read does nothing, and neither does a write of 1. The transmit-empty flag is held at 1 whenever the transmitter is disabled. Three level interrupt requests (transmit, receive and error) are formed from the flags and the two interrupt enables.

Top module: `sci_port_ctl`

Register map (address: contents):
- 0: control. Bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 the transmit enable and bit 4 the receive enable. Bits 3..0 read 0.
- 1: status. Bit 0 is transmit-empty, bit 1 receive-full, bit 2 framing error, bit 3 parity error and bit 4 overrun. Bits 7..5 read 0.
- 2: transmit data (read/write).
- 3: received data (read only).

## Requirements
- R1: After a synchronous reset the control register reads 0x00, status reads 0x01, received data reads 0x00, all three interrupt outputs are 0 and tx_start is 0.
- R2: The control register stores write data bits 7..4 with the layout above, and reads back 0 in bits 3..0 whatever was written there.
- R3: irq_tx is 1 exactly while the transmit interrupt enable (control bit 7) is 1 and the visible transmit-empty flag (status bit 0) is 1.
- R4: irq_rx equals receive interrupt enable AND receive-full. irq_err equals receive interrupt enable AND (framing OR parity OR overrun).
- R5: A status write clears a flag only where the written bit is 0 and that flag was read as 1 by a status read since the flag was last set. A write of 0 without such a read leaves the flag unchanged, and a written 1 never changes a flag.
- R6: While transmit enable is 0, status bit 0 reads 1 and a status write cannot clear it, even after it was read as 1.
- R7: When transmit enable is 1 and a status write clears transmit-empty, tx_start is 1 for exactly one cycle after that write's clock edge, and tx_byte carries the transmit data register.
- R8: A tx_taken pulse sets transmit-empty back to 1.
- R9: With receive enable 1, an rx_start pulse opens a reception. The next rx_done loads rx_byte into the received data register, sets receive-full, and sets framing or parity from rx_ferr and rx_perr. An rx_done with no open reception is ignored.
- R10: With receive enable 0, rx_start and rx_done change nothing. Clearing receive enable leaves receive-full, framing, parity and overrun unchanged.
- R11: A completed byte that arrives while receive-full is 1 sets overrun and leaves the received data register and the other flags unchanged.
- R12: Clearing an interrupt enable withdraws the corresponding pending interrupt on the next cycle, without changing any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; status reads arm flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| tx_taken | input | 1 | Pulse: shifter has taken the transmit byte |
| rx_start | input | 1 | Pulse: start bit detected |
| rx_done | input | 1 | Pulse: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with rx_done |
| rx_ferr | input | 1 | Framing error qualifier, valid with rx_done |
| rx_perr | input | 1 | Parity error qualifier, valid with rx_done |
| tx_start | output | 1 | One-cycle pulse asking the shifter to send tx_byte |
| tx_byte | output | 8 | Contents of the transmit data register |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
A wrong arm bit is invisible until software tries to clear a flag. It then shows as a flag that survives a legal clear, or one that vanishes on an unauthorised write, on the status read and the interrupt lines in the very next cycle. A bad transmit-empty state appears at once on irq_tx and in status bit 0, and a missed or doubled tx_start shows in the single cycle after the clearing write. Receive-side faults surface at the first completed byte, as a changed received data value or a wrong overrun bit.

// File: rtl/sci_ctl_pkg.sv
package sci_ctl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int CTL_W  = 4;
    localparam int NFLAG  = 5;

    localparam int STAT_TDE = 0;
    localparam int STAT_RDF = 1;
    localparam int STAT_FRM = 2;
    localparam int STAT_PAR = 3;
    localparam int STAT_OVR = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTL  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_TXD  = 2'd2,
        SEL_RXD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic tx_irq_en;
        logic rx_irq_en;
        logic tx_en;
        logic rx_en;
    } ctl_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
    } irq_t;

    function automatic logic [DATA_W-1:0] ctl_to_byte(input ctl_t c);
        return {c, {(DATA_W-CTL_W){1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] flags_to_byte(input logic [NFLAG-1:0] f);
        return {{(DATA_W-NFLAG){1'b0}}, f};
    endfunction
endpackage

// File: rtl/sci_ctl_reg.sv
module sci_ctl_reg
    import sci_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wbits,
    output ctl_t             ctl_q
);
    always_ff @(posedge clk) begin
        if (rst)        ctl_q <= '0;
        else if (wr_en) ctl_q <= ctl_t'(wbits);
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_q)) else $error("control changed without write"); // R2
endmodule

// File: rtl/sci_stat_flags.sv
module sci_stat_flags
    import sci_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [NFLAG-1:0] wbits,
    input  logic             tx_taken,
    input  logic             rx_start,
    input  logic             rx_done,
    input  logic             rx_ferr,
    input  logic             rx_perr,
    output logic [NFLAG-1:0] flags_vis,
    output logic             tde_cleared,
    output logic             rx_load,
    output logic             rx_ovr
);
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] arm_q;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] clr_ok;
    logic             rx_act_q;
    logic             rx_accept;

    // reception window opened by a start-bit event
    always_ff @(posedge clk) begin
        if (rst || !rx_en)  rx_act_q <= 1'b0;
        else if (rx_start)  rx_act_q <= 1'b1;
        else if (rx_done)   rx_act_q <= 1'b0;
    end

    assign rx_accept = rx_done && rx_en && rx_act_q;
    assign rx_load   = rx_accept && !flag_q[STAT_RDF];
    assign rx_ovr    = rx_accept &&  flag_q[STAT_RDF];

    always_comb begin
        flags_vis           = flag_q;
        flags_vis[STAT_TDE] = flag_q[STAT_TDE] | ~tx_en;

        set_ev              = '0;
        set_ev[STAT_TDE]    = tx_taken | (~tx_en & ~flag_q[STAT_TDE]);
        set_ev[STAT_RDF]    = rx_load;
        set_ev[STAT_FRM]    = rx_load & rx_ferr;
        set_ev[STAT_PAR]    = rx_load & rx_perr;
        set_ev[STAT_OVR]    = rx_ovr;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam logic RST_VAL = (i == STAT_TDE);
        logic may_clear;
        if (i == STAT_TDE) begin : g_tde
            assign may_clear = tx_en;
        end else begin : g_rx
            assign may_clear = 1'b1;
        end

        assign clr_ok[i] = stat_wr & ~wbits[i] & arm_q[i] & ~set_ev[i] & may_clear;

        always_ff @(posedge clk) begin
            if (rst)            flag_q[i] <= RST_VAL;
            else if (set_ev[i]) flag_q[i] <= 1'b1;
            else if (clr_ok[i]) flag_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)                              arm_q[i] <= 1'b0;
            else if (set_ev[i] || clr_ok[i])      arm_q[i] <= 1'b0;
            else if (stat_rd && flags_vis[i])     arm_q[i] <= 1'b1;
        end
    end

    assign tde_cleared = clr_ok[STAT_TDE];

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q[STAT_RDF]) |-> $past(arm_q[STAT_RDF])) else $error("unarmed clear"); // R5
    AST_TDE_FORCED: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> flag_q[STAT_TDE]) else $error("empty flag not forced"); // R6
    AST_RX_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !stat_wr) |=> $stable(flag_q[STAT_OVR:STAT_RDF])) else $error("rx flags moved"); // R10
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst)
        rx_ovr |=> flag_q[STAT_OVR]) else $error("overrun lost"); // R11
endmodule

// File: rtl/sci_irq_gen.sv
module sci_irq_gen
    import sci_ctl_pkg::*;
(
    input  ctl_t             ctl,
    input  logic [NFLAG-1:0] flags,
    output irq_t             irq
);
    always_comb begin
        irq.tx  = ctl.tx_irq_en & flags[STAT_TDE];
        irq.rx  = ctl.rx_irq_en & flags[STAT_RDF];
        irq.err = ctl.rx_irq_en & (flags[STAT_FRM] | flags[STAT_PAR] | flags[STAT_OVR]);
    end
endmodule

// File: rtl/sci_port_ctl.sv
module sci_port_ctl
    import sci_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_taken,
    input  logic              rx_start,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    reg_sel_e          sel;
    ctl_t              ctl;
    logic [NFLAG-1:0]  flags;
    logic              tde_cleared;
    logic              rx_load;
    logic              rx_ovr;
    logic [DATA_W-1:0] tdr_q;
    logic [DATA_W-1:0] rdr_q;
    logic              tx_start_q;
    irq_t              irq;

    assign sel = reg_sel_e'(bus_addr);

    sci_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && sel == SEL_CTL),
        .wbits (bus_wdata[DATA_W-1:DATA_W-CTL_W]),
        .ctl_q (ctl)
    );

    sci_stat_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .tx_en       (ctl.tx_en),
        .rx_en       (ctl.rx_en),
        .stat_rd     (bus_rd && sel == SEL_STAT),
        .stat_wr     (bus_wr && sel == SEL_STAT),
        .wbits       (bus_wdata[NFLAG-1:0]),
        .tx_taken    (tx_taken),
        .rx_start    (rx_start),
        .rx_done     (rx_done),
        .rx_ferr     (rx_ferr),
        .rx_perr     (rx_perr),
        .flags_vis   (flags),
        .tde_cleared (tde_cleared),
        .rx_load     (rx_load),
        .rx_ovr      (rx_ovr)
    );

    sci_irq_gen u_irq (
        .ctl   (ctl),
        .flags (flags),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tdr_q      <= '0;
            rdr_q      <= '0;
            tx_start_q <= 1'b0;
        end else begin
            if (bus_wr && sel == SEL_TXD) tdr_q <= bus_wdata;
            if (rx_load)                  rdr_q <= rx_byte;
            tx_start_q <= tde_cleared;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTL:  bus_rdata = ctl_to_byte(ctl);
            SEL_STAT: bus_rdata = flags_to_byte(flags);
            SEL_TXD:  bus_rdata = tdr_q;
            default:  bus_rdata = rdr_q;
        endcase
    end

    assign tx_start = tx_start_q;
    assign tx_byte  = tdr_q;
    assign irq_tx   = irq.tx;
    assign irq_rx   = irq.rx;
    assign irq_err  = irq.err;

    AST_TX_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start) else $error("start pulse too long"); // R7
    AST_START_NEEDS_TE: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(ctl.tx_en)) else $error("start while disabled"); // R7
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_ovr |=> $stable(rdr_q)) else $error("data overwritten"); // R11
    AST_TX_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> ctl.tx_irq_en) else $error("tx irq ungated"); // R3
    AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (irq_err || irq_rx) |-> ctl.rx_irq_en) else $error("rx irq ungated"); // R4
endmodule

// File: tb/sim_sci_port_ctl.sv
module sim_sci_port_ctl;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tx_taken, rx_start, rx_done, rx_ferr, rx_perr;
    logic [7:0] rx_byte, tx_byte;
    logic       tx_start, irq_tx, irq_rx, irq_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sci_port_ctl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_taken(tx_taken),
        .rx_start(rx_start), .rx_done(rx_done), .rx_byte(rx_byte), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr), .tx_start(tx_start), .tx_byte(tx_byte),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

    // {rd, addr, wdata, expected rdata (reads) , expected {tx,rx,err}}
    localparam int NV = 18;
    localparam logic [21:0] VECS [NV] = '{
        {1'b1, A_CTL,  8'h00, 8'h00, 3'b000},  // R1
        {1'b0, A_CTL,  8'hF0, 8'h00, 3'b100},  // R2 R3
        {1'b1, A_CTL,  8'h00, 8'hF0, 3'b100},  // R2
        {1'b0, A_CTL,  8'hFF, 8'h00, 3'b100},  // R2
        {1'b1, A_CTL,  8'h00, 8'hF0, 3'b100},  // R2 low bits read 0
        {1'b0, A_STAT, 8'h00, 8'h00, 3'b100},  // R5 unarmed write
        {1'b1, A_STAT, 8'h00, 8'h01, 3'b100},  // R5 still set
        {1'b0, A_TXD,  8'hA5, 8'h00, 3'b100},  // R7
        {1'b1, A_TXD,  8'h00, 8'hA5, 3'b100},  // R7
        {1'b0, A_STAT, 8'hFE, 8'h00, 3'b000},  // R5 R7 armed clear
        {1'b1, A_STAT, 8'h00, 8'h00, 3'b000},  // R3
        {1'b0, A_CTL,  8'hD0, 8'h00, 3'b100},  // R6 forced empty
        {1'b1, A_STAT, 8'h00, 8'h01, 3'b100},  // R6
        {1'b0, A_STAT, 8'h00, 8'h00, 3'b100},  // R6 cannot clear
        {1'b1, A_STAT, 8'h00, 8'h01, 3'b100},  // R6
        {1'b0, A_CTL,  8'h70, 8'h00, 3'b000},  // R12
        {1'b1, A_CTL,  8'h00, 8'h70, 3'b000},  // R12
        {1'b0, A_CTL,  8'h00, 8'h00, 3'b000}   // R2
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] irqs();
        return {5'b0, irq_tx, irq_rx, irq_err};
    endfunction

    // starts and ends at a falling edge
    task automatic access(input bit rd, input logic [1:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd, input string req);
        bus_addr = a; bus_wr = !rd; bus_rd = rd; bus_wdata = d;
        #1;
        if (rd) check(req, bus_rdata, exp_rd);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        access(1'b1, a, 8'h00, exp, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        access(1'b0, a, d, 8'h00, "");
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        tx_taken = 0; rx_start = 0; rx_done = 0; rx_ferr = 0; rx_perr = 0;
    endtask

    task automatic rx_byte_in(input logic [7:0] b, input bit fe, input bit pe);
        rx_start = 1; idle();
        rx_done = 1; rx_byte = b; rx_ferr = fe; rx_perr = pe; idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        tx_taken = 0; rx_start = 0; rx_done = 0; rx_byte = 0; rx_ferr = 0; rx_perr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 irq", irqs(), 8'h00);
        check("R1 tx_start", {7'b0, tx_start}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VECS[i];
            access(v[21], v[20:19], v[18:11], v[10:3], $sformatf("R2-table row %0d rdata", i));
            check($sformatf("R3 table row %0d irq", i), irqs(), {5'b0, v[2:0]});
        end

        // transmit path
        wr(A_CTL, 8'hA0);
        check("R3 irq", irqs(), 8'h04);
        wr(A_TXD, 8'h3C);
        rd_chk(A_STAT, 8'h01, "R5 arm");
        wr(A_STAT, 8'h00);
        check("R7 tx_start", {7'b0, tx_start}, 8'h01);
        check("R7 tx_byte", tx_byte, 8'h3C);
        check("R3 irq off", irqs(), 8'h00);
        idle();
        check("R7 single pulse", {7'b0, tx_start}, 8'h00);
        tx_taken = 1; idle();
        check("R8 irq", irqs(), 8'h04);
        rd_chk(A_STAT, 8'h01, "R8 status");
        wr(A_CTL, 8'hA0);
        wr(A_STAT, 8'h00);   // armed by the read above: clears
        check("R7 second start", {7'b0, tx_start}, 8'h01);
        tx_taken = 1; idle();
        wr(A_STAT, 8'h00);   // not read since set: ignored
        check("R5 no start", {7'b0, tx_start}, 8'h00);
        rd_chk(A_STAT, 8'h01, "R5 unarmed");

        // receive path
        wr(A_CTL, 8'h50);
        rx_done = 1; rx_byte = 8'h11; idle();
        rd_chk(A_STAT, 8'h01, "R9 done without start");
        rx_byte_in(8'h3C, 1'b1, 1'b0);
        check("R4 irq", irqs(), 8'h03);
        rd_chk(A_STAT, 8'h07, "R9 status");
        rd_chk(A_RXD, 8'h3C, "R9 data");
        rx_byte_in(8'h77, 1'b0, 1'b1);
        rd_chk(A_STAT, 8'h17, "R11 status");
        rd_chk(A_RXD, 8'h3C, "R11 data kept");
        wr(A_CTL, 8'h40);
        check("R10 irq", irqs(), 8'h03);
        rd_chk(A_STAT, 8'h17, "R10 flags kept");
        rx_byte_in(8'h99, 1'b1, 1'b1);
        rd_chk(A_STAT, 8'h17, "R10 ignored");
        rd_chk(A_RXD, 8'h3C, "R10 data");
        wr(A_CTL, 8'h10);
        check("R12 irq withdrawn", irqs(), 8'h00);
        rd_chk(A_STAT, 8'h17, "R12 flags kept");
        wr(A_CTL, 8'h50);
        wr(A_STAT, 8'hFF);
        rd_chk(A_STAT, 8'h17, "R5 write one");
        wr(A_STAT, 8'h00);
        rd_chk(A_STAT, 8'h01, "R5 armed clear");
        check("R4 irq clear", irqs(), 8'h00);
        rx_byte_in(8'h5A, 1'b0, 1'b1);
        check("R4 irq parity", irqs(), 8'h03);
        wr(A_STAT, 8'h00);
        rd_chk(A_STAT, 8'h0B, "R5 unarmed after set");
        rd_chk(A_RXD, 8'h5A, "R9 new data");

        // reset from a dirty state
        wr(A_CTL, 8'hF0);
        rst = 1; idle(); idle();
        rst = 0;
        rd_chk(A_CTL, 8'h00, "R1 ctl");
        rd_chk(A_STAT, 8'h01, "R1 status");
        rd_chk(A_RXD, 8'h00, "R1 data");
        check("R1 irq after", irqs(), 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule